// File: doc/BRIEF.md
# Joinable Transmit/Receive FIFO Pair

Two word-wide FIFOs share a single storage array. The transmit FIFO carries words from the host to the engine. The receive FIFO carries words from the engine back to the host. In the normal split, each direction owns half of the array.

Two single-bit join inputs can hand the whole array to one direction, which doubles that direction's depth.
- The direction that gives up its half is disabled. It shows full and empty together, ignores pushes, and reads as zero.
- If both join inputs are high, both directions are disabled.
- Any change on either join input flushes both FIFOs, so no stale word survives a repartition.

Each FIFO has a push strobe with write data, a pop strobe, full and empty flags, and a show-ahead read word. The read word is the head entry whenever the FIFO is not empty, and 0 when it is empty.

Top module: `joinable_fifo_pair`

## Requirements
- R1: After reset, both FIFOs are empty and not full, and both read words are 0.
- R2: With both join inputs low, each FIFO holds DEPTH (4) words, returns them in push order, and raises full after the fourth push.
- R3: A push to a full FIFO is dropped and a pop from an empty FIFO has no effect; the contents and order of the queue are unchanged.
- R4: With only join_tx high, the transmit FIFO holds 2*DEPTH (8) words in order, and the receive FIFO shows full=1 and empty=1.
- R5: With only join_rx high, the receive FIFO holds 2*DEPTH (8) words in order, and the transmit FIFO shows full=1 and empty=1.
- R6: A disabled FIFO ignores pushes and its read word stays 0. Any FIFO that is empty presents a read word of 0.
- R7: The clock edge that first sees a new value on either join input empties both FIFOs. No push or pop takes effect in that cycle.
- R8: With both join inputs high, both FIFOs show full=1 and empty=1 and ignore all pushes.
- R9: In the split mode, the two FIFOs operate in the same cycle without disturbing each other's data.
- R10: A push and a pop in the same cycle on a FIFO that is neither full nor empty keep its level and its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| join_tx | input | 1 | Give the whole array to the transmit FIFO |
| join_rx | input | 1 | Give the whole array to the receive FIFO |
| tx_push | input | 1 | Write strobe, transmit FIFO |
| tx_wdata | input | WIDTH | Write word, transmit FIFO |
| tx_pop | input | 1 | Read strobe, transmit FIFO |
| tx_rdata | output | WIDTH | Head word of the transmit FIFO (0 when empty) |
| tx_full | output | 1 | Transmit FIFO full (or disabled) |
| tx_empty | output | 1 | Transmit FIFO empty (or disabled) |
| rx_push | input | 1 | Write strobe, receive FIFO |
| rx_wdata | input | WIDTH | Write word, receive FIFO |
| rx_pop | input | 1 | Read strobe, receive FIFO |
| rx_rdata | output | WIDTH | Head word of the receive FIFO (0 when empty) |
| rx_full | output | 1 | Receive FIFO full (or disabled) |
| rx_empty | output | 1 | Receive FIFO empty (or disabled) |

## Verification
The hardest case to reach is a flush that discards live data. Both FIFOs must already hold words when a join input toggles. Afterwards the FIFO must come back empty in its new mode and, once the join returns to split, must not expose the old words.

The stimulus therefore loads both directions, toggles join_tx, checks the flags one edge later, then toggles join_tx back and checks again. Joined-depth wrap and pushes against a disabled direction are reached the same way: the join input is set first, and the work starts on the following edge.

// File: rtl/joinable_fifo_pair.sv
module joinable_fifo_pair #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             join_tx,
  input  logic             join_rx,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic             rx_full,
  output logic             rx_empty
);
  localparam int SLOTS = 2 * DEPTH;
  localparam int AW    = $clog2(SLOTS);
  localparam int CW    = $clog2(SLOTS + 1);

  logic [WIDTH-1:0] mem [SLOTS];
  logic             mode_tx, mode_rx;
  logic [AW-1:0]    tx_wi, tx_ri, rx_wi, rx_ri;
  logic [CW-1:0]    tx_cnt, rx_cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] i, input logic [CW-1:0] cap);
    return ((CW'(i) + CW'(1)) == cap) ? '0 : i + AW'(1);
  endfunction

  wire flush  = (join_tx != mode_tx) | (join_rx != mode_rx);
  wire tx_off = mode_rx;
  wire rx_off = mode_tx;

  wire [CW-1:0] tx_cap  = mode_tx ? CW'(SLOTS) : CW'(DEPTH);
  wire [CW-1:0] rx_cap  = mode_rx ? CW'(SLOTS) : CW'(DEPTH);
  wire [AW-1:0] rx_base = mode_rx ? '0 : AW'(DEPTH);

  assign tx_full  = tx_off | (tx_cnt == tx_cap);
  assign tx_empty = tx_off | (tx_cnt == '0);
  assign rx_full  = rx_off | (rx_cnt == rx_cap);
  assign rx_empty = rx_off | (rx_cnt == '0);

  wire tx_wr = tx_push & ~tx_full  & ~flush;
  wire tx_rd = tx_pop  & ~tx_empty & ~flush;
  wire rx_wr = rx_push & ~rx_full  & ~flush;
  wire rx_rd = rx_pop  & ~rx_empty & ~flush;

  assign tx_rdata = tx_empty ? '0 : mem[tx_ri];
  assign rx_rdata = rx_empty ? '0 : mem[rx_base + rx_ri];

  always_ff @(posedge clk) begin
    if (tx_wr) mem[tx_wi] <= tx_wdata;
    if (rx_wr) mem[rx_base + rx_wi] <= rx_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_tx <= 1'b0;
      mode_rx <= 1'b0;
      tx_wi <= '0; tx_ri <= '0; tx_cnt <= '0;
      rx_wi <= '0; rx_ri <= '0; rx_cnt <= '0;
    end else if (flush) begin
      mode_tx <= join_tx;
      mode_rx <= join_rx;
      tx_wi <= '0; tx_ri <= '0; tx_cnt <= '0;
      rx_wi <= '0; rx_ri <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wi <= step(tx_wi, tx_cap);
      if (tx_rd) tx_ri <= step(tx_ri, tx_cap);
      if (tx_wr & ~tx_rd) tx_cnt <= tx_cnt + CW'(1);
      else if (tx_rd & ~tx_wr) tx_cnt <= tx_cnt - CW'(1);
      if (rx_wr) rx_wi <= step(rx_wi, rx_cap);
      if (rx_rd) rx_ri <= step(rx_ri, rx_cap);
      if (rx_wr & ~rx_rd) rx_cnt <= rx_cnt + CW'(1);
      else if (rx_rd & ~rx_wr) rx_cnt <= rx_cnt - CW'(1);
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= tx_cap) && (rx_cnt <= rx_cap));
  p_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop && !flush) |=> $stable(tx_cnt));
  p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !rx_push && !flush) |=> (rx_cnt == '0));
  p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_off |-> tx_cnt == '0) and (rx_off |-> rx_cnt == '0));
  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty |-> tx_rdata == '0) and (rx_empty |-> rx_rdata == '0));
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_cnt == '0 && rx_cnt == '0));
  p_both_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tx && mode_rx) |-> (tx_full && tx_empty && rx_full && rx_empty));
endmodule

// File: tb/tb_joinable_fifo_pair.sv
module tb_joinable_fifo_pair;
  logic clk = 0, rst_n = 0, join_tx = 0, join_rx = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic tx_full, tx_empty, rx_full, rx_empty;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  joinable_fifo_pair dut (.*);

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flags(string req, logic tf, logic te, logic rf, logic re);
    chk(req, {28'd0, tx_full, tx_empty, rx_full, rx_empty}, {28'd0, tf, te, rf, re});
  endtask

  task automatic put_tx(logic [31:0] d);
    tx_push = 1; tx_wdata = d; step(); tx_push = 0;
  endtask

  task automatic put_rx(logic [31:0] d);
    rx_push = 1; rx_wdata = d; step(); rx_push = 0;
  endtask

  task automatic get_tx(string req, logic [31:0] e);
    chk(req, tx_rdata, e); tx_pop = 1; step(); tx_pop = 0;
  endtask

  task automatic get_rx(string req, logic [31:0] e);
    chk(req, rx_rdata, e); rx_pop = 1; step(); rx_pop = 0;
  endtask

  task automatic t_reset();
    flags("R1 flags", 0, 1, 0, 1);
    chk("R1 tx_rdata", tx_rdata, 0);
    chk("R1 rx_rdata", rx_rdata, 0);
  endtask

  task automatic t_split_order();
    for (int i = 0; i < 4; i++) begin
      chk("R2 tx not full", {31'd0, tx_full}, 0);
      put_tx(32'hA000 + i);
    end
    for (int i = 0; i < 4; i++) put_rx(32'hB000 + i);
    flags("R2 both full", 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) get_tx("R2 tx order", 32'hA000 + i);
    for (int i = 0; i < 4; i++) get_rx("R2 rx order", 32'hB000 + i);
    flags("R2 both empty", 0, 1, 0, 1);
  endtask

  task automatic t_bounds();
    for (int i = 0; i < 4; i++) put_tx(32'h10 + i);
    put_tx(32'hDEAD);
    for (int i = 0; i < 4; i++) get_tx("R3 overflow dropped", 32'h10 + i);
    chk("R3 empty after drain", {31'd0, tx_empty}, 1);
    tx_pop = 1; step(); tx_pop = 0;
    put_tx(32'h77);
    get_tx("R3 underflow no effect", 32'h77);
    chk("R3 empty again", {31'd0, tx_empty}, 1);
  endtask

  task automatic t_same_cycle();
    put_rx(32'h1); put_rx(32'h2);
    rx_push = 1; rx_wdata = 32'h3; rx_pop = 1; step(); rx_push = 0; rx_pop = 0;
    get_rx("R10 level kept", 32'h2);
    get_rx("R10 order kept", 32'h3);
    chk("R10 empty", {31'd0, rx_empty}, 1);
  endtask

  task automatic t_parallel();
    for (int i = 0; i < 3; i++) begin
      tx_push = 1; tx_wdata = 32'hC0 + i; rx_push = 1; rx_wdata = 32'hD0 + i;
      step(); tx_push = 0; rx_push = 0;
    end
    for (int i = 0; i < 3; i++) begin
      chk("R9 tx data", tx_rdata, 32'hC0 + i);
      chk("R9 rx data", rx_rdata, 32'hD0 + i);
      tx_pop = 1; rx_pop = 1; step(); tx_pop = 0; rx_pop = 0;
    end
    flags("R9 both empty", 0, 1, 0, 1);
  endtask

  task automatic t_join_tx();
    join_tx = 1; step();
    flags("R4 rx disabled", 0, 1, 1, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R4 tx not full yet", {31'd0, tx_full}, 0);
      put_tx(32'hE0 + i);
    end
    chk("R4 tx full at 8", {31'd0, tx_full}, 1);
    put_rx(32'hBAD);
    chk("R6 rx push ignored rdata", rx_rdata, 0);
    flags("R6 rx still disabled", 1, 0, 1, 1);
    for (int i = 0; i < 3; i++) get_tx("R4 tx order", 32'hE0 + i);
    for (int i = 0; i < 3; i++) put_tx(32'hF0 + i);
    for (int i = 3; i < 8; i++) get_tx("R4 tx order wrap", 32'hE0 + i);
    for (int i = 0; i < 3; i++) get_tx("R4 tx wrapped", 32'hF0 + i);
    chk("R4 tx empty", {31'd0, tx_empty}, 1);
    join_tx = 0; step();
  endtask

  task automatic t_join_rx();
    join_rx = 1; step();
    flags("R5 tx disabled", 1, 1, 0, 1);
    for (int i = 0; i < 8; i++) put_rx(32'h5000 + i);
    chk("R5 rx full at 8", {31'd0, rx_full}, 1);
    put_tx(32'hBAD);
    chk("R6 tx rdata zero", tx_rdata, 0);
    for (int i = 0; i < 8; i++) get_rx("R5 rx order", 32'h5000 + i);
    join_rx = 0; step();
    flags("R5 back to split", 0, 1, 0, 1);
  endtask

  task automatic t_flush();
    put_tx(32'h11); put_tx(32'h12); put_rx(32'h21);
    join_tx = 1; step();
    flags("R7 flushed on set", 0, 1, 1, 1);
    join_tx = 0; step();
    flags("R7 flushed on clear", 0, 1, 0, 1);
    chk("R7 old tx data gone", tx_rdata, 0);
    put_rx(32'h33);
    get_rx("R7 rx fresh", 32'h33);
  endtask

  task automatic t_both();
    join_tx = 1; join_rx = 1; step();
    flags("R8 both disabled", 1, 1, 1, 1);
    tx_push = 1; rx_push = 1; tx_wdata = 1; rx_wdata = 2; step(); tx_push = 0; rx_push = 0;
    chk("R8 tx rdata", tx_rdata, 0);
    chk("R8 rx rdata", rx_rdata, 0);
    join_tx = 0; join_rx = 0; step();
    flags("R8 split empty", 0, 1, 0, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    t_reset();
    t_split_order();
    t_bounds();
    t_same_cycle();
    t_parallel();
    t_join_tx();
    t_join_rx();
    t_flush();
    t_both();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule